// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receiving half of an inter-core mailbox. Another core pushes 64-bit messages into it, each carrying a 3-bit source channel tag. The messages wait in a circular queue until a host processor takes them out through a small memory-mapped register window.

The host reads the oldest message as three separate words: the tag, the lower 32 bits and the upper 32 bits. It then writes a trigger register to discard that entry and bring the next one forward. The host works out the fill level from a status word. That word carries the raw read and write pointers and a full flag. The full flag tells a full queue apart from an empty one when the two pointers are equal.

An interrupt line tells the host that messages have arrived. A single mask bit gates it, and the host clears the pending bit by writing to it. A register read returns its data on the clock after the request. Pushes use a plain valid/data interface with no back-pressure.

Top module: `rxq_mailbox`

## Requirements
- R1: After reset the status word reads 0, the pending word reads 0, the mask reads 0x1F, `rx_irq` is low, and the depth register at 0x24 reads DEPTH-1 (7 by default).
- R2: A push with `rx_valid` high stores the tag, low word and high word. Reads at 0x0 (tag, zero-extended), 0x4 (low word) and 0x8 (high word) return the oldest stored message. While the queue is empty all three read 0.
- R3: The status word at 0x14 holds the read pointer in bits 31:24, the write pointer in bits 23:16 and the full flag in bit 0, with every other bit 0. Both pointers count entries and wrap from DEPTH-1 to 0. The full flag is 1 exactly when DEPTH entries are held.
- R4: A push while the queue is full is dropped. Neither pointer, the full flag nor the stored messages change.
- R5: A write to 0xC with bit 0 set removes the oldest message and advances the read pointer. A write to 0xC with bit 0 clear, or a removal attempted while the queue is empty, changes nothing.
- R6: Writing the value 0 to 0x10 empties the queue: both pointers return to 0 and the full flag clears. Writing any non-zero value to 0x10 has no effect.
- R7: Bit 0 of the pending word at 0x18 sets on every accepted push. A write to 0x18 with bit 0 set clears it. When a push and a clear land in the same cycle, the push wins.
- R8: The mask register at 0x1C keeps the low 5 bits written to it. `rx_irq` is high exactly when the pending bit is 1 and mask bit 0 is 0. It updates on the same clock edge as the pending bit and the mask.
- R9: `reg_rdata` presents the addressed value on the clock edge that samples `reg_rd`. Addresses with no register read 0.
- R10: A push and a removal in the same cycle on a queue that is neither empty nor full are both performed. Both pointers advance and the full flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Push one message this cycle |
| rx_lo | input | 32 | Lower message word to push |
| rx_hi | input | 32 | Upper message word to push |
| rx_id | input | 3 | Source channel tag to push |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| rx_irq | output | 1 | Message-arrived interrupt, registered |

## Verification
The bench fills the queue until the pointers meet with the full flag set, then pushes once more. A design that let the overflow push through would advance the write pointer or overwrite the oldest entry, and the next eight removals would return the wrong words.

It then drains the queue across the pointer wrap and tries a removal on an empty queue. A wrong wrap or an unguarded removal shows up as a bad pointer field in the status word.

A push and a removal land in one cycle, and a push and an interrupt clear land in another. A design that serialised the first would leave a stale head entry. One that let the clear win would drop an arrival notice.

Non-zero writes to the queue reset register and trigger writes with bit 0 clear must leave the status untouched. A loose decode would empty the queue or remove entries by accident.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_ID_W   = 3;
  localparam int RXQ_WORD_W = 32;
  localparam int RXQ_MASK_W = 5;

  localparam logic [7:0] OFS_TAG   = 8'h00;
  localparam logic [7:0] OFS_LO    = 8'h04;
  localparam logic [7:0] OFS_HI    = 8'h08;
  localparam logic [7:0] OFS_POP   = 8'h0C;
  localparam logic [7:0] OFS_CLR   = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_PEND  = 8'h18;
  localparam logic [7:0] OFS_MASK  = 8'h1C;
  localparam logic [7:0] OFS_DEPTH = 8'h24;

  typedef struct packed {
    logic [RXQ_ID_W-1:0]   tag;
    logic [RXQ_WORD_W-1:0] hi;
    logic [RXQ_WORD_W-1:0] lo;
  } rxq_msg_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  rxq_msg_t         msg_i,
  input  logic             pop_i,
  input  logic             clr_i,
  output rxq_msg_t         head_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             push_acc_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rxq_msg_t         mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic             full_q;
  logic             empty, push_acc, pop_acc;
  logic [PTR_W-1:0] rd_inc, wr_inc;

  assign empty    = (rd_q == wr_q) && !full_q;
  assign push_acc = push_i && !full_q && !clr_i;
  assign pop_acc  = pop_i && !empty && !clr_i;
  assign rd_inc   = (rd_q == LAST) ? '0 : rd_q + 1'b1;
  assign wr_inc   = (wr_q == LAST) ? '0 : wr_q + 1'b1;

  // storage: single write port, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_q] <= msg_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      rd_q   <= '0;
      wr_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (push_acc) wr_q <= wr_inc;
      if (pop_acc)  rd_q <= rd_inc;
      if (push_acc && !pop_acc && (wr_inc == rd_q)) full_q <= 1'b1;
      else if (pop_acc && !push_acc)                full_q <= 1'b0;
    end
  end

  assign head_o     = mem[rd_q];
  assign rd_ptr_o   = rd_q;
  assign wr_ptr_o   = wr_q;
  assign full_o     = full_q;
  assign empty_o    = empty;
  assign push_acc_o = push_acc;

  a_r3_full_ptrs_meet: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (rd_q == wr_q));
  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    (rd_q <= LAST) && (wr_q <= LAST));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full_q && push_i && !pop_i && !clr_i) |=> (wr_q == $past(wr_q)) && full_q);
  a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_i && !push_i && !clr_i) |=> (rd_q == $past(rd_q)));
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (rd_q == '0) && (wr_q == '0) && !full_q);
  a_r10_both_move: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !empty && !full_q && !clr_i)
      |=> (rd_q != $past(rd_q)) && (wr_q != $past(wr_q)) && !full_q);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_i,
  input  logic                  clr_i,
  input  logic                  mask_we_i,
  input  logic [RXQ_MASK_W-1:0] mask_wdata_i,
  output logic                  pend_o,
  output logic [RXQ_MASK_W-1:0] mask_o,
  output logic                  irq_o
);
  logic                  pend_q, pend_d, irq_q;
  logic [RXQ_MASK_W-1:0] mask_q, mask_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;     // arrival beats clear
    mask_d = mask_we_i ? mask_wdata_i : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq_q  <= pend_d && !mask_d[0];
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r7_push_sets_pending: assert property (@(posedge clk) disable iff (rst)
    set_i |=> pend_q);
  a_r7_clear_alone: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !pend_q);
  a_r8_line_needs_pending: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (pend_q && !mask_q[0]));
  a_r8_line_follows: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !mask_q[0]) |-> irq_q);
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [RXQ_WORD_W-1:0] wdata_i,
  input  rxq_msg_t              head_i,
  input  logic [PTR_W-1:0]      rd_ptr_i,
  input  logic [PTR_W-1:0]      wr_ptr_i,
  input  logic                  full_i,
  input  logic                  empty_i,
  input  logic                  pend_i,
  input  logic [RXQ_MASK_W-1:0] mask_i,
  output logic                  pop_o,
  output logic                  fifo_clr_o,
  output logic                  pend_clr_o,
  output logic                  mask_we_o,
  output logic [RXQ_WORD_W-1:0] rdata_o
);
  logic [RXQ_WORD_W-1:0] rdata_q, rd_mux;
  logic [7:0]            rd8, wr8;

  assign rd8 = 8'(rd_ptr_i);
  assign wr8 = 8'(wr_ptr_i);

  assign pop_o      = wr_i && (addr_i == ADDR_W'(OFS_POP)) && wdata_i[0];
  assign fifo_clr_o = wr_i && (addr_i == ADDR_W'(OFS_CLR)) && (wdata_i == '0);
  assign pend_clr_o = wr_i && (addr_i == ADDR_W'(OFS_PEND)) && wdata_i[0];
  assign mask_we_o  = wr_i && (addr_i == ADDR_W'(OFS_MASK));

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(OFS_TAG):   if (!empty_i) rd_mux = RXQ_WORD_W'(head_i.tag);
      ADDR_W'(OFS_LO):    if (!empty_i) rd_mux = head_i.lo;
      ADDR_W'(OFS_HI):    if (!empty_i) rd_mux = head_i.hi;
      ADDR_W'(OFS_STAT):  rd_mux = {rd8, wr8, 15'd0, full_i};
      ADDR_W'(OFS_PEND):  rd_mux = RXQ_WORD_W'(pend_i);
      ADDR_W'(OFS_MASK):  rd_mux = RXQ_WORD_W'(mask_i);
      ADDR_W'(OFS_DEPTH): rd_mux = RXQ_WORD_W'(DEPTH - 1);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  a_r3_status_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == ADDR_W'(OFS_STAT)) |=> (rdata_q[15:1] == '0));
  a_r9_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/rxq_mailbox.sv
module rxq_mailbox
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic [RXQ_WORD_W-1:0] rx_lo,
  input  logic [RXQ_WORD_W-1:0] rx_hi,
  input  logic [RXQ_ID_W-1:0]   rx_id,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [RXQ_WORD_W-1:0] reg_wdata,
  output logic [RXQ_WORD_W-1:0] reg_rdata,
  output logic                  rx_irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxq_msg_t              in_msg, head;
  logic [PTR_W-1:0]      rd_ptr, wr_ptr;
  logic                  full, empty, push_acc;
  logic                  pop, fifo_clr, pend_clr, mask_we, pend;
  logic [RXQ_MASK_W-1:0] mask;

  assign in_msg = '{tag: rx_id, hi: rx_hi, lo: rx_lo};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push_i(rx_valid), .msg_i(in_msg), .pop_i(pop),
    .clr_i(fifo_clr), .head_o(head), .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr),
    .full_o(full), .empty_o(empty), .push_acc_o(push_acc)
  );

  rxq_irq u_irq (
    .clk(clk), .rst(rst), .set_i(push_acc), .clr_i(pend_clr),
    .mask_we_i(mask_we), .mask_wdata_i(reg_wdata[RXQ_MASK_W-1:0]),
    .pend_o(pend), .mask_o(mask), .irq_o(rx_irq)
  );

  rxq_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .head_i(head), .rd_ptr_i(rd_ptr), .wr_ptr_i(wr_ptr),
    .full_i(full), .empty_i(empty), .pend_i(pend), .mask_i(mask),
    .pop_o(pop), .fifo_clr_o(fifo_clr), .pend_clr_o(pend_clr),
    .mask_we_o(mask_we), .rdata_o(reg_rdata)
  );
endmodule

// File: tb/sim_rxq_mailbox.sv
module sim_rxq_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_lo = '0, rx_hi = '0;
  logic [2:0]  rx_id = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_irq;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rxq_mailbox u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_lo(rx_lo), .rx_hi(rx_hi),
    .rx_id(rx_id), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq)
  );

  // row: {op, req, addr, data, expected}; op 0 read, 1 write, 2 push
  localparam int NV = 27;
  localparam logic [77:0] VEC [NV] = '{
    {2'd0, 4'd1,  8'h14, 32'h0,        32'h0},         // R1 status
    {2'd0, 4'd1,  8'h1C, 32'h0,        32'h0000001F},  // R1 mask
    {2'd0, 4'd1,  8'h24, 32'h0,        32'h7},         // R1 depth
    {2'd0, 4'd1,  8'h18, 32'h0,        32'h0},         // R1 pending
    {2'd0, 4'd2,  8'h00, 32'h0,        32'h0},         // R2 empty head
    {2'd2, 4'd2,  8'h00, 32'h11110005, 32'h0},
    {2'd2, 4'd2,  8'h00, 32'h22220003, 32'h0},
    {2'd0, 4'd3,  8'h14, 32'h0,        32'h00020000},  // R3
    {2'd0, 4'd2,  8'h00, 32'h0,        32'h5},         // R2 tag
    {2'd0, 4'd2,  8'h04, 32'h0,        32'h11110005},  // R2 lo
    {2'd0, 4'd2,  8'h08, 32'h0,        32'hEEEEFFFA},  // R2 hi
    {2'd0, 4'd7,  8'h18, 32'h0,        32'h1},         // R7 set
    {2'd1, 4'd7,  8'h18, 32'h1,        32'h0},
    {2'd0, 4'd7,  8'h18, 32'h0,        32'h0},         // R7 cleared
    {2'd1, 4'd5,  8'h0C, 32'h0,        32'h0},
    {2'd0, 4'd5,  8'h14, 32'h0,        32'h00020000},  // R5 bit0 clear ignored
    {2'd1, 4'd5,  8'h0C, 32'h1,        32'h0},
    {2'd0, 4'd5,  8'h14, 32'h0,        32'h01020000},  // R5 pop
    {2'd0, 4'd5,  8'h04, 32'h0,        32'h22220003},  // R5 next head
    {2'd0, 4'd5,  8'h00, 32'h0,        32'h3},
    {2'd1, 4'd5,  8'h0C, 32'h1,        32'h0},
    {2'd0, 4'd5,  8'h14, 32'h0,        32'h02020000},
    {2'd1, 4'd5,  8'h0C, 32'h1,        32'h0},
    {2'd0, 4'd5,  8'h14, 32'h0,        32'h02020000},  // R5 empty pop ignored
    {2'd0, 4'd9,  8'h30, 32'h0,        32'h0},         // R9 unmapped
    {2'd1, 4'd8,  8'h1C, 32'hFFFFFFFE, 32'h0},
    {2'd0, 4'd8,  8'h1C, 32'h0,        32'h0000001E}   // R8 five bits kept
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle of stimulus; effects visible at the next negedge
  task automatic drive(input logic push, input logic [31:0] lo, input logic wr,
                       input logic [7:0] addr, input logic [31:0] wd);
    @(negedge clk);
    rx_valid = push; rx_lo = lo; rx_hi = ~lo; rx_id = lo[2:0];
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    @(negedge clk);
    rx_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] lo);
    drive(1'b1, lo, 1'b0, 8'h0, 32'h0);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
    drive(1'b0, 32'h0, 1'b1, addr, wd);
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = addr;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [77:0] v;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", {31'd0, rx_irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      case (v[77:76])
        2'd0: begin
          rd(v[71:64], d);
          chk($sformatf("R%0d row %0d", v[75:72], i), d, v[31:0]);
        end
        2'd1: wr(v[71:64], v[63:32]);
        default: push(v[63:32]);
      endcase
    end

    // R8: mask bit0 now 0 (mask 0x1E), pending 0
    chk("R8 idle", {31'd0, rx_irq}, 32'd0);
    push(32'h0000_0AA1);
    chk("R8 unmasked fires", {31'd0, rx_irq}, 32'd1);
    wr(8'h1C, 32'h1F);
    chk("R8 masked", {31'd0, rx_irq}, 32'd0);
    rd(8'h18, d);
    chk("R8 pending kept", d, 32'd1);
    wr(8'h18, 32'h1);
    wr(8'h0C, 32'h1);                       // rd=wr=3

    // R3/R4: fill, overflow, drain across wrap
    for (int i = 0; i < 8; i++) push(32'hA0 + i);
    rd(8'h14, d);
    chk("R3 full", d, 32'h03030001);
    push(32'hDEAD);
    rd(8'h14, d);
    chk("R4 overflow ptrs", d, 32'h03030001);
    for (int i = 0; i < 8; i++) begin
      rd(8'h04, d);
      chk("R4 contents", d, 32'hA0 + i);
      wr(8'h0C, 32'h1);
    end
    rd(8'h14, d);
    chk("R3 wrap empty", d, 32'h03030000);

    // R10: push and pop together
    push(32'hB1);
    drive(1'b1, 32'hB2, 1'b1, 8'h0C, 32'h1);
    rd(8'h14, d);
    chk("R10 ptrs", d, 32'h04050000);
    rd(8'h04, d);
    chk("R10 head", d, 32'hB2);

    // R7: push beats clear
    wr(8'h18, 32'h1);
    rd(8'h18, d);
    chk("R7 clear", d, 32'd0);
    drive(1'b1, 32'hC3, 1'b1, 8'h18, 32'h1);
    rd(8'h18, d);
    chk("R7 push wins", d, 32'd1);

    // R6: queue reset
    wr(8'h10, 32'h5);
    rd(8'h14, d);
    chk("R6 nonzero ignored", d, 32'h04060000);
    wr(8'h10, 32'h0);
    rd(8'h14, d);
    chk("R6 cleared", d, 32'h0);
    rd(8'h04, d);
    chk("R2 empty after reset", d, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule